// File: doc/BRIEF.md
# Five-Layer Alpha Compositing Pipeline

This block takes one beat per pixel, carrying the data of five display layers, and produces one 24-bit RGB colour per beat. The bottom layer is an opaque RGB565 backdrop. When the backdrop is switched off, the background colour input takes its place. The layer above it is RGB565 with a single programmable opacity. The three upper layers each carry an 8-bit index into a private 256-entry colour table. Each table entry returns an RGB666 colour and a 6-bit per-pixel opacity. Layers are stacked from the bottom up, one blend stage per layer. The weight of a layer is its pixel opacity times its programmable opacity. A layer that is switched off or lies outside its picture-in-picture window gets weight zero.

Beats enter and leave through valid/ready handshakes. The pipeline stalls as a whole: when the output holds a beat that the consumer does not take, every stage freezes and `in_ready` drops in the same cycle. A beat is transferred on a rising edge where valid and ready are both high. The layer enables, opacities and background colour are plain control pins. They are captured together with the beat they apply to. The colour tables are loaded through a simple write port.

Top module: `pixel_blend_engine`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A beat accepted on a rising edge shows on `out_valid`/`out_rgb` after the fifth rising edge, counting the accepting edge as the first, when `out_ready` stays high. Beats leave in the order they entered, and none is lost or duplicated.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and on the next cycle `out_valid` is still 1 with `out_rgb` unchanged.
- R4: An RGB565 word has red in [15:11], green in [10:5] and blue in [4:0]. A table entry has its opacity in [23:18], red in [17:12], green in [11:6] and blue in [5:0]. Each 5-bit or 6-bit colour field is widened to 8 bits by appending its top 3 or 2 bits. `out_rgb` holds red in [23:16], green in [15:8] and blue in [7:0].
- R5: The base colour is `in_l0` when `lay_en[0]` is 1, and `bg_color` (RGB565) otherwise.
- R6: A 6-bit opacity a becomes the weight a + a[5], which runs from 0 to 64. Layer k (1..4) has the weight (Wpix*Wlayer)>>6. Wlayer comes from `lay_alpha[(k-1)*6 +: 6]`. Wpix comes from the table entry for layers 2..4 and is fixed at 64 for layer 1.
- R7: Layers 1, 2, 3 and 4 are blended in that order over the running result. Each channel is computed as (top*w + below*(64-w))>>6.
- R8: Layer k (1..4) has weight 0, so its pixel data has no effect, when `lay_en[k]` is 0 or when `in_win[k-1]` is 0.
- R9: A write with `pal_we` stores `pal_data` at `pal_addr` in the table of layer 2, 3 or 4 for `pal_sel` 0, 1 or 2. That layer looks up its index, taken from `in_idx[(k-2)*8 +: 8]`, in this table.
- R10: When all bits of `lay_en` are 0, the output equals `bg_color` widened per R4.
- R11: Enables, opacities, windows and background are used as they stand in the cycle the beat is accepted. Later changes do not alter a beat already accepted.
- R12: A layer with both opacities at 63, enabled and inside its window, gives its own colour exactly, whatever lies below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken this cycle |
| in_l0 | input | 16 | Backdrop pixel, RGB565 |
| in_l1 | input | 16 | Layer 1 pixel, RGB565 |
| in_idx | input | 24 | Table indices of layers 2..4, 8 bits each, layer 2 lowest |
| in_win | input | 4 | Inside-window flags of layers 1..4 |
| lay_en | input | 5 | Enables of layers 0..4 |
| lay_alpha | input | 24 | Programmable 6-bit opacities of layers 1..4, layer 1 lowest |
| bg_color | input | 16 | Background colour, RGB565 |
| pal_we | input | 1 | Table write strobe |
| pal_sel | input | 2 | Table select: 0, 1, 2 for layers 2, 3, 4 |
| pal_addr | input | 8 | Table entry written |
| pal_data | input | 24 | Entry value: opacity and RGB666 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_rgb | output | 24 | Blended colour, 8 bits per channel |

## Verification
The properties assume that `out_ready` is the only cause of a stall. They also assume that the tables are written only while no beat that reads the written entry is in flight, because a lookup and a write to the same entry in one cycle return the old entry. The stimulus loads every table entry before any beat is sent. It keeps each beat and its control values steady from the moment it is offered until it is accepted. It drops `out_ready` at random so that stalls land on every stage. Opacities are drawn with extra weight on 0 and 63, so that the pass-through and fully opaque paths of each blend stage are exercised often.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int ALPHA_W = 6;
  localparam int WT_W    = 7;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  function automatic rgb_t from565(input logic [15:0] v);
    rgb_t c;
    c.r = {v[15:11], v[15:13]};
    c.g = {v[10:5], v[10:9]};
    c.b = {v[4:0], v[4:2]};
    return c;
  endfunction

  function automatic rgb_t from666(input logic [17:0] v);
    rgb_t c;
    c.r = {v[17:12], v[17:16]};
    c.g = {v[11:6], v[11:10]};
    c.b = {v[5:0], v[5:4]};
    return c;
  endfunction

  // 0..63 mapped onto 0..64 so that 63 is exact unity
  function automatic logic [WT_W-1:0] alpha_wt(input logic [ALPHA_W-1:0] a);
    return {1'b0, a} + {{(WT_W-1){1'b0}}, a[ALPHA_W-1]};
  endfunction

  function automatic logic [WT_W-1:0] wt_mul(input logic [WT_W-1:0] a,
                                             input logic [WT_W-1:0] b);
    logic [2*WT_W-1:0] p;
    p = {{WT_W{1'b0}}, a} * {{WT_W{1'b0}}, b};
    return WT_W'(p >> 6);
  endfunction

  function automatic logic [7:0] mix8(input logic [7:0] t, input logic [7:0] b,
                                      input logic [WT_W-1:0] w);
    logic [14:0] s;
    s = 15'(t) * 15'(w) + 15'(b) * 15'(7'd64 - w);
    return 8'(s >> 6);
  endfunction
endpackage

// File: rtl/pxb_palette.sv
module pxb_palette #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pxb_blend.sv
module pxb_blend
  import pxb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            in_valid,
  input  rgb_t            below,
  input  rgb_t            top,
  input  logic [WT_W-1:0] wt,
  output logic            out_valid,
  output rgb_t            out_col
);
  rgb_t mixed;

  always_comb begin
    mixed.r = mix8(top.r, below.r, wt);
    mixed.g = mix8(top.g, below.g, wt);
    mixed.b = mix8(top.b, below.b, wt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_col   <= '0;
    end else if (adv) begin
      out_valid <= in_valid;
      out_col   <= mixed;
    end
  end

  // R6
  wt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> wt <= 7'd64);

  // R8
  zero_wt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid && wt == '0) |=> out_col == $past(below));

  // R12
  full_wt_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid && wt == 7'd64) |=> out_col == $past(top));
endmodule

// File: rtl/pixel_blend_engine.sv
module pixel_blend_engine
  import pxb_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int NPAL  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [15:0]              in_l0,
  input  logic [15:0]              in_l1,
  input  logic [NPAL*IDX_W-1:0]    in_idx,
  input  logic [NPAL:0]            in_win,
  input  logic [NPAL+1:0]          lay_en,
  input  logic [(NPAL+1)*6-1:0]    lay_alpha,
  input  logic [15:0]              bg_color,
  input  logic                     pal_we,
  input  logic [$clog2(NPAL)-1:0]  pal_sel,
  input  logic [IDX_W-1:0]         pal_addr,
  input  logic [23:0]              pal_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [23:0]              out_rgb
);
  localparam int NUP   = NPAL + 1;      // layers blended over the base
  localparam int LAY_W = 24 + WT_W;     // colour plus effective weight

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Capture stage: base colour, layer-1 colour, controls
  logic                  s1_valid;
  rgb_t                  s1_base, s1_l1;
  logic [NUP-1:0]        s1_on;
  logic [NUP*6-1:0]      s1_la;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_base  <= '0;
      s1_l1    <= '0;
      s1_on    <= '0;
      s1_la    <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_base  <= lay_en[0] ? from565(in_l0) : from565(bg_color);
      s1_l1    <= from565(in_l1);
      s1_on    <= lay_en[NUP:1] & in_win;
      s1_la    <= lay_alpha;
    end
  end

  // Colour tables, looked up in step with the capture stage
  logic [23:0] pal_q [0:NPAL-1];

  for (genvar p = 0; p < NPAL; p++) begin : g_pal
    pxb_palette #(.IDX_W(IDX_W), .ENT_W(24)) u_pal (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (pal_we && (pal_sel == p)),
      .waddr (pal_addr),
      .wdata (pal_data),
      .re    (adv),
      .raddr (in_idx[p*IDX_W +: IDX_W]),
      .rdata (pal_q[p])
    );
  end

  // Per-layer colour and weight, delayed to meet its blend stage
  logic [LAY_W-1:0] lay_d [1:NUP];

  for (genvar k = 1; k <= NUP; k++) begin : g_lay
    rgb_t             col;
    logic [WT_W-1:0]  wpix, eff;
    logic [LAY_W-1:0] tap [0:k-1];

    if (k == 1) begin : g_direct
      assign col  = s1_l1;
      assign wpix = 7'd64;
    end else begin : g_table
      assign col  = from666(pal_q[k-2][17:0]);
      assign wpix = alpha_wt(pal_q[k-2][23:18]);
    end

    assign eff    = s1_on[k-1] ? wt_mul(wpix, alpha_wt(s1_la[(k-1)*6 +: 6])) : '0;
    assign tap[0] = {col, eff};

    for (genvar i = 1; i < k; i++) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   tap[i] <= '0;
        else if (adv) tap[i] <= tap[i-1];
      end
    end

    assign lay_d[k] = tap[k-1];
  end

  // Blend chain, bottom layer first
  rgb_t acc [0:NUP];
  logic vld [0:NUP];

  assign acc[0] = s1_base;
  assign vld[0] = s1_valid;

  for (genvar j = 1; j <= NUP; j++) begin : g_stage
    pxb_blend u_blend (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .in_valid  (vld[j-1]),
      .below     (acc[j-1]),
      .top       (rgb_t'(lay_d[j][LAY_W-1:WT_W])),
      .wt        (lay_d[j][WT_W-1:0]),
      .out_valid (vld[j]),
      .out_col   (acc[j])
    );
  end

  assign out_valid = vld[NUP];
  assign out_rgb   = acc[NUP];

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));
endmodule

// File: tb/tb_pixel_blend_engine.sv
`timescale 1ns/1ps
module tb_pixel_blend_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] l0 = '0, l1 = '0, bg = '0;
  logic [23:0] idx = '0, la = '0;
  logic [3:0]  win = '0;
  logic [4:0]  en = '0;
  logic        pal_we = 1'b0;
  logic [1:0]  pal_sel = '0;
  logic [7:0]  pal_addr = '0;
  logic [23:0] pal_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [23:0] out_rgb;

  int checks = 0, errors = 0;
  bit rnd_ready = 1'b0;
  logic [23:0] pal_m [0:2][0:255];
  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  pixel_blend_engine dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_l0(l0), .in_l1(l1), .in_idx(idx), .in_win(win), .lay_en(en),
    .lay_alpha(la), .bg_color(bg), .pal_we(pal_we), .pal_sel(pal_sel),
    .pal_addr(pal_addr), .pal_data(pal_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_rgb(out_rgb)
  );

  function automatic logic [23:0] c565(input logic [15:0] v);
    return {v[15:11], v[15:13], v[10:5], v[10:9], v[4:0], v[4:2]};
  endfunction
  function automatic logic [23:0] c666(input logic [17:0] v);
    return {v[17:12], v[17:16], v[11:6], v[11:10], v[5:0], v[5:4]};
  endfunction
  function automatic int wt(input logic [5:0] a);
    return int'(a) + (a[5] ? 1 : 0);
  endfunction
  function automatic logic [7:0] mixc(input logic [7:0] t, input logic [7:0] b, input int w);
    return 8'((int'(t) * w + int'(b) * (64 - w)) >> 6);
  endfunction

  function automatic logic [23:0] model();
    logic [23:0] acc, col, e;
    int wp, w;
    acc = en[0] ? c565(l0) : c565(bg);
    for (int k = 1; k <= 4; k++) begin
      if (k == 1) begin
        col = c565(l1); wp = 64;
      end else begin
        e = pal_m[k-2][idx[(k-2)*8 +: 8]];
        col = c666(e[17:0]); wp = wt(e[23:18]);
      end
      w = (en[k] && win[k-1]) ? (wp * wt(la[(k-1)*6 +: 6])) / 64 : 0;
      acc = {mixc(col[23:16], acc[23:16], w), mixc(col[15:8], acc[15:8], w),
             mixc(col[7:0], acc[7:0], w)};
    end
    return acc;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_ready();
    out_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
  endtask

  task automatic send(input string tag);
    logic [23:0] e;
    bit acc;
    e = model();
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1'b1;
      drive_ready();
      #1;
      if (in_ready) begin
        exp_q.push_back(e);
        tag_q.push_back(tag);
        acc = 1'b1;
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      drive_ready();
    end
  endtask

  function automatic logic [5:0] pick_alpha();
    case ($urandom % 4)
      0: return 6'd0;
      1: return 6'd63;
      default: return 6'($urandom);
    endcase
  endfunction

  task automatic rand_beat();
    l0 = 16'($urandom); l1 = 16'($urandom); bg = 16'($urandom);
    idx = 24'($urandom);
    win = 4'($urandom);
    en = 5'($urandom);
    la = {pick_alpha(), pick_alpha(), pick_alpha(), pick_alpha()};
  endtask

  // Output monitor: ordering, values, stall behaviour
  bit        held = 1'b0;
  logic [23:0] held_rgb;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (held) begin
        // R3 output held through a stall
        chk("R3", {7'd0, out_valid, out_rgb}, {8'd1, held_rgb});
        held = 1'b0;
      end
      if (out_valid && !out_ready) begin
        chk("R3", {31'd0, in_ready}, 32'd0);
        held = 1'b1;
        held_rgb = out_rgb;
      end
      if (out_valid && out_ready && rst_n) begin
        if (exp_q.size() == 0) begin
          chk("R2", 32'd1, 32'd0);
        end else begin
          string t;
          t = tag_q.pop_front();
          chk(t, {8'd0, out_rgb}, {8'd0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1", {30'd0, out_valid, in_ready}, 32'd1);

    // R9 load every table entry
    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        pal_we = 1'b1; pal_sel = 2'(s); pal_addr = 8'(a);
        pal_data = (s == 2 && a == 7) ? 24'hFC0FC0 : 24'($urandom);
        pal_m[s][a] = pal_data;
      end
    end
    @(negedge clk); pal_we = 1'b0;
    idle(4);

    // R2 latency with a single beat
    rand_beat(); en = 5'b00001;
    send("R2");
    n = 0;
    do begin
      @(negedge clk); in_valid = 1'b0; n++; #3;
    end while (!out_valid && n < 20);
    chk("R2", n, 5);
    idle(4);

    // R10 nothing enabled
    rand_beat(); en = 5'b00000; send("R10");
    // R4 and R5 backdrop only, then background replacing it
    rand_beat(); en = 5'b00001; l0 = 16'hF81F; send("R4");
    rand_beat(); en = 5'b11110; win = 4'b0000; send("R5");
    // R12 opaque layer 1 over backdrop
    rand_beat(); en = 5'b00011; win = 4'b0001; la[5:0] = 6'd63; send("R12");
    // R6 partial weight, white over black
    rand_beat(); en = 5'b00011; win = 4'b0001; la[5:0] = 6'd32;
    l0 = 16'h0000; l1 = 16'hFFFF; send("R6");
    // R8 all enabled but outside every window
    rand_beat(); en = 5'b11111; win = 4'b0000; la = '1; send("R8");
    // R9 table of layer 4, entry 7 opaque
    rand_beat(); en = 5'b10001; win = 4'b1000; la[23:18] = 6'd63;
    idx[23:16] = 8'd7; send("R9");
    idle(8);

    // R11 controls change right after each accepted beat under stalls
    rnd_ready = 1'b1;
    for (int i = 0; i < 40; i++) begin
      rand_beat(); send("R11");
    end
    // R7 random stream
    for (int i = 0; i < 3000; i++) begin
      rand_beat(); send("R7");
    end
    rnd_ready = 1'b0;
    n = 0;
    while (exp_q.size() != 0 && n < 200) begin
      idle(1); n++;
    end
    idle(3);
    chk("R2", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule